// File: doc/BRIEF.md
# Cycle-Counting Interrupt Timer

This block is a 16-bit up-counter that advances once per CPU bus cycle. It pulls an active-low interrupt line when the count rolls over from all ones while the interrupt is armed. Software places a start value straight into the live counter, four bits at a time, through four write addresses. It arms or disarms the interrupt at a fifth address and clears a pending interrupt at a sixth.

The block watches the CPU bus: address lines A14..A12, the low data nibble, R/W, the cartridge ROM select and a one-clock strobe marking each CPU cycle. Every action happens on a strobe clock: a bus write, a count step, an overflow. A write is a strobe with ROM select low and R/W low. The selected 4 KiB window comes from A14..A12. Values 6 and 7 of that field belong to other logic and are ignored here. When the interrupt fires it disarms itself, so each arming gives exactly one interrupt.

Top module: `cyc_irq_timer`

## Requirements
- R1: A write with A14..A12 equal to 0, 1, 2 or 3 loads D3..D0 into counter bits 3..0, 7..4, 11..8 or 15..12 respectively.
- R2: On every strobe without a counter write, the counter increases by one. With the strobe low, nothing changes.
- R3: When a strobe steps the counter from 0xFFFF while armed, the pending flag is set and irq_n is low from the next clock on. irq_n is always the inverse of the pending flag.
- R4: After 0xFFFF the counter wraps to 0x0000 and keeps counting. A rollover while disarmed leaves irq_n high.
- R5: A write with A14..A12 = 4 sets the arm bit to D1; the values of D0, D2 and D3 have no effect.
- R6: A write of any value with A14..A12 = 4'd5 field value 5 clears the pending flag.
- R7: An interrupt firing clears the arm bit, so the next rollover raises nothing unless software arms again.
- R8: A counter-nibble write on a strobe replaces the increment for that cycle: the written nibble takes the new value, and the other nibbles keep their old value.
- R9: Synchronous reset clears the counter, the arm bit and the pending flag, leaving irq_n high.
- R10: Strobes with ROM select high, with R/W high, or with A14..A12 equal to 6 or 7 write nothing and only advance the counter. Bus activity without a strobe does nothing.
- R11: On a strobe where a rollover fires and a write also hits the block: a write of the arm bit takes effect instead of the self-clear, and the firing sets the pending flag even if the same strobe is an acknowledge write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| m2_stb | input | 1 | One-clock pulse per CPU bus cycle |
| romsel_n | input | 1 | Cartridge ROM select, low for the upper 32 KiB |
| cpu_rw | input | 1 | CPU read/write, low for a write |
| cpu_addr | input | 3 | CPU address bits A14..A12 |
| cpu_data | input | 4 | CPU data bits D3..D0 |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The assertions assume that the bus fields are stable and valid whenever m2_stb is high. They also assume that m2_stb is a single-clock pulse, so each CPU cycle is seen exactly once. The stimulus drives all bus lines and the strobe together on the falling clock edge and holds them for one full clock. It then drops the strobe, or follows with another strobed cycle, before the next change. Because only irq_n is visible, the counter contents are checked through interrupt timing: the stimulus loads values near 0xFFFF and counts the strobes until irq_n falls.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;

    localparam int NIB_W     = 4;
    localparam int NUM_NIB   = 4;
    localparam int CNT_W     = NIB_W * NUM_NIB;
    localparam int NIB_IDX_W = $clog2(NUM_NIB);
    localparam int SEL_W     = 3;
    localparam int ARM_BIT   = 1;

    typedef enum logic [SEL_W-1:0] {
        SEL_NIB0  = 3'd0,
        SEL_NIB1  = 3'd1,
        SEL_NIB2  = 3'd2,
        SEL_NIB3  = 3'd3,
        SEL_ARM   = 3'd4,
        SEL_ACK   = 3'd5,
        SEL_EXT_A = 3'd6,
        SEL_EXT_B = 3'd7
    } win_sel_e;

    typedef struct packed {
        logic                 tick;
        logic                 cnt_wr;
        logic [NIB_IDX_W-1:0] nib_idx;
        logic                 arm_wr;
        logic                 ack_wr;
        logic [NIB_W-1:0]     data;
    } bus_cmd_t;

    function automatic bus_cmd_t decode_bus(
        input logic             stb,
        input logic             sel_n,
        input logic             rw,
        input logic [SEL_W-1:0] addr,
        input logic [NIB_W-1:0] d
    );
        bus_cmd_t c;
        logic     wr;
        win_sel_e win;
        wr        = stb & ~sel_n & ~rw;
        win       = win_sel_e'(addr);
        c.tick    = stb;
        c.cnt_wr  = wr && (addr < SEL_W'(NUM_NIB));
        c.nib_idx = addr[NIB_IDX_W-1:0];
        c.arm_wr  = wr && (win == SEL_ARM);
        c.ack_wr  = wr && (win == SEL_ACK);
        c.data    = d;
        return c;
    endfunction

endpackage

// File: rtl/timer_bus_decode.sv
module timer_bus_decode
    import cyc_timer_pkg::*;
(
    input  logic             m2_stb,
    input  logic             romsel_n,
    input  logic             cpu_rw,
    input  logic [SEL_W-1:0] cpu_addr,
    input  logic [NIB_W-1:0] cpu_data,
    output bus_cmd_t         cmd
);
    always_comb begin
        cmd = decode_bus(m2_stb, romsel_n, cpu_rw, cpu_addr, cpu_data);
    end

    // R10: at most one command class per cycle, and only on a strobe
    always_comb begin
        a_r10_one_cmd: assert ($onehot0({cmd.cnt_wr, cmd.arm_wr, cmd.ack_wr}));
        a_r10_no_write_off_strobe: assert (m2_stb || !(cmd.cnt_wr || cmd.arm_wr || cmd.ack_wr));
    end
endmodule

// File: rtl/timer_counter.sv
module timer_counter
    import cyc_timer_pkg::*;
#(
    parameter int W   = CNT_W,
    parameter int NW  = NIB_W,
    parameter int NN  = NUM_NIB,
    parameter int IXW = NIB_IDX_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    input  logic           cnt_wr,
    input  logic [IXW-1:0] nib_idx,
    input  logic [NW-1:0]  data,
    output logic           wrap
);
    localparam logic [W-1:0] ALL_ONES = '1;

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_wr) begin
            for (int k = 0; k < NN; k++) begin
                if (nib_idx == IXW'(k)) cnt_d[k*NW +: NW] = data;
            end
        end else if (tick) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign wrap = tick && !cnt_wr && (cnt_q == ALL_ONES);

    generate
        for (genvar g = 0; g < NN; g++) begin : g_nib_chk
            a_r1_nibble_load: assert property (@(posedge clk) disable iff (rst)
                (cnt_wr && nib_idx == IXW'(g)) |=> cnt_q[g*NW +: NW] == $past(data));
            a_r8_nibble_hold: assert property (@(posedge clk) disable iff (rst)
                (cnt_wr && nib_idx != IXW'(g)) |=> $stable(cnt_q[g*NW +: NW]));
        end
    endgenerate

    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr) |=> cnt_q == W'($past(cnt_q) + W'(1)));
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_wr) |=> $stable(cnt_q));
    a_r4_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        wrap |=> cnt_q == '0);
    a_r9_reset_clear: assert property (@(posedge clk)
        rst |=> cnt_q == '0);
endmodule

// File: rtl/timer_irq_flag.sv
module timer_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic wrap,
    input  logic arm_wr,
    input  logic arm_val,
    input  logic ack_wr,
    output logic pending
);
    logic arm_q;
    logic fire;

    assign fire = wrap && arm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q   <= 1'b0;
            pending <= 1'b0;
        end else begin
            if (arm_wr)    arm_q <= arm_val;
            else if (fire) arm_q <= 1'b0;

            if (fire)        pending <= 1'b1;
            else if (ack_wr) pending <= 1'b0;
        end
    end

    a_r3_fire_sets: assert property (@(posedge clk) disable iff (rst)
        (wrap && arm_q) |=> pending);
    a_r4_disarmed_quiet: assert property (@(posedge clk) disable iff (rst)
        (wrap && !arm_q && !pending) |=> !pending);
    a_r5_arm_load: assert property (@(posedge clk) disable iff (rst)
        arm_wr |=> arm_q == $past(arm_val));
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ack_wr && !(wrap && arm_q)) |=> !pending);
    a_r7_self_disarm: assert property (@(posedge clk) disable iff (rst)
        (wrap && arm_q && !arm_wr) |=> !arm_q);
    a_r9_reset_flags: assert property (@(posedge clk)
        rst |=> (!pending && !arm_q));
endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
    import cyc_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             m2_stb,
    input  logic             romsel_n,
    input  logic             cpu_rw,
    input  logic [SEL_W-1:0] cpu_addr,
    input  logic [NIB_W-1:0] cpu_data,
    output logic             irq_n
);
    bus_cmd_t cmd;
    logic     wrap;
    logic     pending;

    timer_bus_decode i_decode (
        .m2_stb   (m2_stb),
        .romsel_n (romsel_n),
        .cpu_rw   (cpu_rw),
        .cpu_addr (cpu_addr),
        .cpu_data (cpu_data),
        .cmd      (cmd)
    );

    timer_counter i_counter (
        .clk     (clk),
        .rst     (rst),
        .tick    (cmd.tick),
        .cnt_wr  (cmd.cnt_wr),
        .nib_idx (cmd.nib_idx),
        .data    (cmd.data),
        .wrap    (wrap)
    );

    timer_irq_flag i_flag (
        .clk     (clk),
        .rst     (rst),
        .wrap    (wrap),
        .arm_wr  (cmd.arm_wr),
        .arm_val (cmd.data[ARM_BIT]),
        .ack_wr  (cmd.ack_wr),
        .pending (pending)
    );

    assign irq_n = ~pending;

    a_r3_irq_follows: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_n) |-> $past(wrap));
endmodule

// File: tb/test_cyc_irq_timer.sv
`timescale 1ns/1ps
module test_cyc_irq_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m2_stb = 1'b0;
    logic       romsel_n = 1'b1;
    logic       cpu_rw = 1'b1;
    logic [2:0] cpu_addr = 3'd0;
    logic [3:0] cpu_data = 4'd0;
    logic       irq_n;

    always #2.5 clk = ~clk;

    cyc_irq_timer i_cyc_irq_timer (
        .clk(clk), .rst(rst), .m2_stb(m2_stb), .romsel_n(romsel_n),
        .cpu_rw(cpu_rw), .cpu_addr(cpu_addr), .cpu_data(cpu_data), .irq_n(irq_n)
    );

    typedef struct { logic exp; string tag; } exp_t;
    exp_t q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // reference state built from the requirements
    logic [15:0] m_cnt = 16'd0;
    logic        m_arm = 1'b0;
    logic        m_pend = 1'b0;

    // monitor: pop one expectation per falling edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_checks++;
            if (irq_n !== e.exp) begin
                n_fail++;
                $display("FAIL %s: irq_n=%b expected %b at %0t", e.tag, irq_n, e.exp, $time);
            end
        end
    end

    task automatic push(input string tag);
        exp_t e;
        e.exp = ~m_pend;
        e.tag = tag;
        q.push_back(e);
    endtask

    // one clock of bus activity; st = strobe
    task automatic cyc(input bit st, input bit sn, input bit rw,
                       input logic [2:0] a, input logic [3:0] d, input string tag);
        bit wr, cw, fire;
        @(negedge clk);
        m2_stb = st; romsel_n = sn; cpu_rw = rw; cpu_addr = a; cpu_data = d;
        @(posedge clk);
        wr   = st && !sn && !rw;
        cw   = wr && (a < 3'd4);
        fire = st && !cw && (m_cnt == 16'hFFFF) && m_arm;
        if (cw) m_cnt[a[1:0]*4 +: 4] = d;
        else if (st) m_cnt = m_cnt + 16'd1;
        if (wr && a == 3'd4) m_arm = d[1];
        else if (fire) m_arm = 1'b0;
        if (fire) m_pend = 1'b1;
        else if (wr && a == 3'd5) m_pend = 1'b0;
        push(tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [3:0] d, input string tag);
        cyc(1'b1, 1'b0, 1'b0, a, d, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b1, 1'b1, 3'd0, 4'd0, tag);
    endtask

    task automatic load(input logic [15:0] v, input string tag);
        for (int k = 0; k < 4; k++) wr(3'(k), v[k*4 +: 4], tag);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1; m2_stb = 1'b0;
        @(posedge clk);
        m_cnt = 16'd0; m_arm = 1'b0; m_pend = 1'b0;
        push(tag);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset("R9 reset state");
        idle(3, "R9 idle after reset");

        // R1 R3: load near top, arm, count to rollover
        load(16'hFFFA, "R1 load");
        wr(3'd4, 4'hF, "R5 arm");
        idle(8, "R3 fire at rollover");
        wr(3'd5, 4'h0, "R6 ack value 0");
        idle(2, "R6 stays clear");

        // R7: fired arm cleared, next rollover silent
        load(16'hFFFE, "R7 load");
        idle(5, "R7 no second fire");

        // R5: D1 clear disarms though other bits set
        wr(3'd4, 4'hD, "R5 arm bit low");
        load(16'hFFFD, "R5 load");
        idle(5, "R5 disarmed quiet");
        wr(3'd4, 4'h2, "R5 arm bit only");
        load(16'hFFF0, "R4 load");
        idle(20, "R4 wrap and fire");
        wr(3'd5, 4'hA, "R6 ack any value");

        // R2 R4: nibble weights checked by timing, gaps without strobe
        wr(3'd4, 4'h2, "R2 arm");
        load(16'hFFE3, "R1 load mixed nibbles");
        for (int i = 0; i < 30; i++) begin
            cyc(1'b0, 1'b0, 1'b0, 3'd4, 4'h0, "R10 no strobe");
            idle(1, "R2 count step");
        end
        wr(3'd5, 4'h5, "R6 ack");

        // R10: ignored writes advance count only
        wr(3'd4, 4'h2, "R10 arm");
        load(16'hFFF8, "R10 load");
        cyc(1'b1, 1'b1, 1'b0, 3'd4, 4'h0, "R10 romsel high");
        cyc(1'b1, 1'b0, 1'b1, 3'd0, 4'h0, "R10 read cycle");
        cyc(1'b1, 1'b0, 1'b0, 3'd6, 4'h0, "R10 window 6");
        cyc(1'b1, 1'b0, 1'b0, 3'd7, 4'h0, "R10 window 7");
        idle(6, "R10 fire on time");
        cyc(1'b1, 1'b1, 1'b0, 3'd5, 4'h0, "R10 ack ignored");
        cyc(1'b1, 1'b0, 1'b0, 3'd6, 4'h0, "R10 still pending");
        wr(3'd5, 4'h0, "R6 ack");

        // R8: nibble write at 0xFFFF blocks increment
        wr(3'd4, 4'h2, "R8 arm");
        load(16'hFFFF, "R8 load");
        wr(3'd0, 4'hF, "R8 write holds FFFF");
        wr(3'd3, 4'hF, "R8 write holds FFFF");
        idle(1, "R8 fires after writes");
        idle(1, "R8 pending");
        wr(3'd5, 4'h0, "R6 ack");

        // R11: ack on fire cycle, pending wins
        wr(3'd4, 4'h2, "R11 arm");
        load(16'hFFFF, "R11 load");
        wr(3'd5, 4'h0, "R11 ack on fire");
        idle(2, "R11 pending kept");
        wr(3'd5, 4'h0, "R6 ack");

        // R11: arm write on fire cycle keeps arm
        wr(3'd4, 4'h2, "R11 arm");
        load(16'hFFFF, "R11 load");
        wr(3'd4, 4'h2, "R11 arm on fire");
        wr(3'd5, 4'h0, "R11 ack");
        load(16'hFFFD, "R11 load again");
        idle(4, "R11 rearmed fires");

        // R9: reset clears pending and arm
        do_reset("R9 reset clears pending");
        load(16'hFFFE, "R9 load");
        idle(4, "R9 arm cleared");

        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule